// File: doc/BRIEF.md
# Wake Event Status Register

This block holds the two live bits of a power management control/status word: a wake-event status flag and a wake enable flag. A one-cycle wake-event pulse sets the status flag whether or not the enable flag is set. Software clears the flag by writing one to it. While both flags are set, the block asserts an active-low wake request, which is registered.

The 32-bit word is written through a port with per-byte enables. It is read back through a combinational read port. All other fields of the word read as zero and ignore writes.

Three synchronous active-low resets are provided: power-up, hardware and software. A static strap declares whether wake signalling is supported from the cold low-power state. When the strap is set, the two flags are sticky: only the power-up reset clears them. When the strap is clear, every reset clears them.

Top module: `wake_status_reg`

## Requirements
- R1: A cycle with `wake_evt` high sets the status bit (bit 15 of the word) at the next rising edge, whatever the enable bit holds.
- R2: A write with `wr_be[1]` high and `wr_data[15]` = 1 clears the status bit. A write with `wr_data[15]` = 0, or with `wr_be[1]` low, leaves it unchanged.
- R3: When a wake event and a clearing write fall in the same cycle, the status bit ends at 1.
- R4: The enable bit (bit 8) takes `wr_data[8]` on a write with `wr_be[1]` high. A write with `wr_be[1]` low leaves it unchanged.
- R5: `wake_req_n` equals NOT(status AND enable) as they stood one clock earlier. It is 1 after a power-up reset.
- R6: With `cold_wake_strap` = 0, a low `rst_hw_n` or `rst_sw_n` at a rising edge clears both the status and enable bits.
- R7: With `cold_wake_strap` = 1, hardware and software resets leave both bits unchanged. A low `rst_por_n` at a rising edge clears both bits regardless of the strap.
- R8: Bits 31:16, 14:9 and 7:0 of `rd_data` always read 0, including after writes of ones with all byte enables set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-up reset, synchronous, active low |
| rst_hw_n | input | 1 | Hardware reset, synchronous, active low |
| rst_sw_n | input | 1 | Software reset, synchronous, active low |
| cold_wake_strap | input | 1 | Static: 1 = wake supported from the cold state, so the flags are sticky |
| wake_evt | input | 1 | Wake-event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register image |
| wake_req_n | output | 1 | Wake request, active low, registered |

## Verification
The bench builds the block with the default parameters: a 32-bit word, the status flag at bit 15 and the enable flag at bit 8. Running both strap values, each behind its own power-up reset, brings the sticky and non-sticky reset paths within reach. The bench also covers the collision of a wake event with a clearing write, and writes with the flag lane disabled while every other lane is enabled.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int WORD_W     = 32;
  localparam int STATUS_POS = 15;
  localparam int ENABLE_POS = 8;

  typedef enum logic {
    CELL_RW  = 1'b0,
    CELL_W1C = 1'b1
  } cell_kind_e;
endpackage

// File: rtl/wake_rst_sel.sv
module wake_rst_sel (
  input  logic por_n,
  input  logic hw_n,
  input  logic sw_n,
  input  logic sticky,
  output logic clr_flags,
  output logic clr_out
);
  logic soft_any;

  assign soft_any  = !hw_n || !sw_n;
  assign clr_flags = !por_n || (!sticky && soft_any);
  assign clr_out   = !por_n;
endmodule

// File: rtl/wake_lane_mask.sv
module wake_lane_mask #(
  parameter int DATA_W = 32
) (
  input  logic                  wr_en,
  input  logic [DATA_W/8-1:0]   be,
  output logic [DATA_W-1:0]     mask
);
  localparam int LANES = DATA_W / 8;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l*8 +: 8] = {8{wr_en & be[l]}};
  end
endmodule

// File: rtl/wake_bit_cell.sv
module wake_bit_cell
  import wake_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_RW
) (
  input  logic clk,
  input  logic clr,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic set_evt,
  output logic q
);
  if (KIND == CELL_W1C) begin : g_w1c
    always_ff @(posedge clk) begin
      if (clr)                 q <= 1'b0;
      else if (set_evt)        q <= 1'b1;
      else if (wr_hit && wr_bit) q <= 1'b0;
    end
  end else begin : g_rw
    always_ff @(posedge clk) begin
      if (clr)         q <= 1'b0;
      else if (wr_hit) q <= wr_bit;
    end
  end
endmodule

// File: rtl/wake_status_reg.sv
module wake_status_reg
  import wake_pkg::*;
#(
  parameter int DATA_W     = WORD_W,
  parameter int STATUS_BIT = STATUS_POS,
  parameter int ENABLE_BIT = ENABLE_POS
) (
  input  logic              clk,
  input  logic              rst_por_n,
  input  logic              rst_hw_n,
  input  logic              rst_sw_n,
  input  logic              cold_wake_strap,
  input  logic              wake_evt,
  input  logic              wr_en,
  input  logic [3:0]        wr_be,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake_req_n
);
  localparam int LANES = DATA_W / 8;

  logic              clr_flags;
  logic              clr_out;
  logic [DATA_W-1:0] wmask;
  logic              st_q;
  logic              en_q;
  logic              req_n_q;

  wake_rst_sel u_rst (
    .por_n     (rst_por_n),
    .hw_n      (rst_hw_n),
    .sw_n      (rst_sw_n),
    .sticky    (cold_wake_strap),
    .clr_flags (clr_flags),
    .clr_out   (clr_out)
  );

  wake_lane_mask #(.DATA_W(DATA_W)) u_mask (
    .wr_en (wr_en),
    .be    (wr_be[LANES-1:0]),
    .mask  (wmask)
  );

  wake_bit_cell #(.KIND(CELL_W1C)) u_status (
    .clk     (clk),
    .clr     (clr_flags),
    .wr_hit  (wmask[STATUS_BIT]),
    .wr_bit  (wr_data[STATUS_BIT]),
    .set_evt (wake_evt),
    .q       (st_q)
  );

  wake_bit_cell #(.KIND(CELL_RW)) u_enable (
    .clk     (clk),
    .clr     (clr_flags),
    .wr_hit  (wmask[ENABLE_BIT]),
    .wr_bit  (wr_data[ENABLE_BIT]),
    .set_evt (1'b0),
    .q       (en_q)
  );

  always_ff @(posedge clk) begin
    if (clr_out) req_n_q <= 1'b1;
    else         req_n_q <= !(st_q && en_q);
  end

  always_comb begin
    rd_data             = '0;
    rd_data[STATUS_BIT] = st_q;
    rd_data[ENABLE_BIT] = en_q;
  end

  assign wake_req_n = req_n_q;
endmodule

// File: rtl/wake_status_reg_chk.sv
module wake_status_reg_chk (
  input logic        clk,
  input logic        rst_por_n,
  input logic        rst_hw_n,
  input logic        rst_sw_n,
  input logic        cold_wake_strap,
  input logic        wake_evt,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        wake_req_n
);
  logic soft_ok;
  assign soft_ok = rst_hw_n && rst_sw_n;

  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (wake_evt && (soft_ok || cold_wake_strap)) |=> rd_data[15]);

  // R2
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (rd_data[15] && !wake_evt && (soft_ok || cold_wake_strap) &&
     !(wr_en && wr_be[1] && wr_data[15])) |=> rd_data[15]);

  // R4
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (wr_en && wr_be[1] && (soft_ok || cold_wake_strap)) |=> (rd_data[8] == $past(wr_data[8])));

  // R5
  req_follow_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    1'b1 |=> (wake_req_n == !($past(rd_data[15]) && $past(rd_data[8]))));

  // R6
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (!cold_wake_strap && !soft_ok) |=> (rd_data[15:8] == 8'h00));

  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    (cold_wake_strap && !soft_ok && !wr_en && !wake_evt) |=> ($stable(rd_data[15]) && $stable(rd_data[8])));

  // R8
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_por_n)
    ((rd_data[31:16] == 16'h0) && (rd_data[14:9] == 6'h0) && (rd_data[7:0] == 8'h0)));
endmodule

bind wake_status_reg wake_status_reg_chk i_chk (
  .clk             (clk),
  .rst_por_n       (rst_por_n),
  .rst_hw_n        (rst_hw_n),
  .rst_sw_n        (rst_sw_n),
  .cold_wake_strap (cold_wake_strap),
  .wake_evt        (wake_evt),
  .wr_en           (wr_en),
  .wr_be           (wr_be),
  .wr_data         (wr_data),
  .rd_data         (rd_data),
  .wake_req_n      (wake_req_n)
);

// File: tb/test_wake_status_reg.sv
`timescale 1ns/1ps
module test_wake_status_reg;
  logic        clk = 1'b0;
  logic        rst_por_n = 1'b0, rst_hw_n = 1'b1, rst_sw_n = 1'b1;
  logic        cold_wake_strap = 1'b0;
  logic        wake_evt = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic [31:0] rd_data;
  logic        wake_req_n;

  int tests = 0, fails = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  logic        m_st = 1'b0, m_en = 1'b0, m_wn = 1'b1;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  wake_status_reg i_wake_status_reg (
    .clk(clk), .rst_por_n(rst_por_n), .rst_hw_n(rst_hw_n), .rst_sw_n(rst_sw_n),
    .cold_wake_strap(cold_wake_strap), .wake_evt(wake_evt), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .wake_req_n(wake_req_n)
  );

  // driver: applies one cycle of stimulus, then queues the expected outputs
  task automatic step(input logic por, input logic hw, input logic sw,
                      input logic evt, input logic we, input logic [3:0] be,
                      input logic [31:0] d, input string tag);
    logic [31:0] img;
    @(negedge clk);
    rst_por_n = por; rst_hw_n = hw; rst_sw_n = sw;
    wake_evt = evt; wr_en = we; wr_be = be; wr_data = d;
    @(posedge clk);
    m_wn = !(m_st && m_en);
    if (!por) begin
      m_st = 1'b0; m_en = 1'b0; m_wn = 1'b1;
    end else if (!cold_wake_strap && (!hw || !sw)) begin
      m_st = 1'b0; m_en = 1'b0;
    end else begin
      if (we && be[1]) m_en = d[8];
      if (evt) m_st = 1'b1;
      else if (we && be[1] && d[15]) m_st = 1'b0;
    end
    img = 32'h0; img[15] = m_st; img[8] = m_en;
    exp_q.push_back({m_wn, img});
    tag_q.push_back(tag);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        tests++;
        if ({wake_req_n, rd_data} !== e) begin
          fails++;
          $display("FAIL %s: got req_n=%b rd=%h, expected req_n=%b rd=%h",
                   t, wake_req_n, rd_data, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // strap 0 phase
    cold_wake_strap = 1'b0;
    step(0,1,1, 0,0,4'h0,32'h0, "R5 reset state");
    step(0,1,1, 0,0,4'h0,32'h0, "R7 por clears");
    step(1,1,1, 0,0,4'h0,32'h0, "R5 idle after reset");
    step(1,1,1, 1,0,4'h0,32'h0, "R1 event with enable off");
    step(1,1,1, 0,0,4'h0,32'h0, "R5 stays high with enable off");
    step(1,1,1, 0,1,4'hD,32'hFFFF_FFFF, "R4 R8 lane1 disabled write ignored");
    step(1,1,1, 0,1,4'h2,32'h0000_0100, "R2 zero to status keeps, R4 enable set");
    step(1,1,1, 0,0,4'h0,32'h0, "R5 request asserts one clock later");
    step(1,1,1, 0,1,4'hF,32'hFFFF_FFFF, "R2 R8 w1c clear, reserved zero");
    step(1,1,1, 0,0,4'h0,32'h0, "R5 request releases");
    step(1,1,1, 1,1,4'h2,32'h0000_8100, "R3 set wins over clear");
    step(1,1,1, 0,0,4'h0,32'h0, "R3 status held");
    step(1,0,1, 0,0,4'h0,32'h0, "R6 hw reset clears non-sticky");
    step(1,1,1, 1,1,4'h2,32'h0000_0100, "R1 R4 rearm");
    step(1,1,0, 0,0,4'h0,32'h0, "R6 sw reset clears non-sticky");
    step(1,1,1, 0,0,4'h0,32'h0, "R5 after soft reset");
    // strap 1 phase
    step(0,1,1, 0,0,4'h0,32'h0, "R7 por before strap change");
    cold_wake_strap = 1'b1;
    step(0,1,1, 0,0,4'h0,32'h0, "R7 por clears with strap set");
    step(1,1,1, 1,1,4'h2,32'h0000_0100, "R1 R4 arm sticky");
    step(1,0,1, 0,0,4'h0,32'h0, "R7 hw reset keeps sticky");
    step(1,1,0, 0,0,4'h0,32'h0, "R7 sw reset keeps sticky");
    step(1,0,0, 0,0,4'h0,32'h0, "R7 both soft resets keep");
    step(1,1,1, 0,1,4'h2,32'h0000_8000, "R2 clear in sticky mode");
    step(1,1,1, 1,0,4'h0,32'h0, "R1 set again");
    step(0,0,0, 0,0,4'h0,32'h0, "R7 por clears sticky bits");
    step(1,1,1, 0,1,4'hF,32'hFFFF_7EFF, "R8 R4 write all but flags");
    step(1,1,1, 0,0,4'h0,32'h0, "R8 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule